// File: doc/BRIEF.md
# Cascaded Rising-Edge Boundary Detector Chain

This block sits behind a row of N capture flip-flops in an on-chip path-delay measurement line. A transition travels down the line, so the captured stage values read like a thermometer: a run of ones followed by zeros. The block finds the boundary, which is the position where one stage has risen to one while the stage after it is still zero. It reports that position as a per-cell detect vector, the complement of that vector, a sticky flag and a binary index.

The block has one detect cell for each adjacent pair of stages. Stages are numbered from 1, and the first cell watches stage 3. Each cell has two storage elements, both clocked registers. The arm element becomes set once its own stage has been seen high. The detect element then follows the next stage, but only while it is enabled. A cell is enabled by its own arm or by a crossover in the cell before it. A crossover therefore ripples up the chain one cell per clock, whether or not the later cells are armed. Software or a controller pulses the initialise strobe before each measurement. After that, the stage vector is sampled on every clock with no extra synchronisation.

Top module: `boundary_detect_chain`

## Requirements
- R1: A cell's arm element becomes 1 at the clock edge where its own stage is sampled high. It then stays 1 until the next initialise, even if that stage later drops. An armed cell keeps loading its next stage.
- R2: A clock edge with `init_i` high forces every arm element to 0, every detect element to 1 and the sticky flag to 0, whatever the stage inputs are. After that edge, `det_o` is all ones, `det_n_o` is all zeros, `xover_seen_o` is 0 and `xover_idx_o` is all ones.
- R3: On an edge without initialise, a cell's detect element loads its next-stage input if, before the edge, its arm element was 1 or the preceding cell's `det_n_o` bit was 1. Otherwise it holds its value. Cell 0 has no preceding cell, and its preceding-cell input is 0.
- R4: When cell c has `det_o` at 0, cell c+1 loads its next stage on the following edge even if it is not armed. A crossover therefore propagates upward one cell per clock.
- R5: `det_n_o` is the bitwise inverse of `det_o` in every cycle.
- R6: `xover_seen_o` is 1 in any cycle where some `det_o` bit is 0. Once it is 1, it stays 1 until an initialise edge, even if every detect bit returns to 1.
- R7: `xover_idx_o` gives the lowest cell number c whose `det_o` bit is 0, or all ones when no bit is 0. Cell c watches stage c+3 as its own stage and stage c+4 as its next stage. Stage s is `stage_q_i[s-1]`. Bit c of `det_o` and `det_n_o` belongs to cell c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; all storage updates on its rising edge |
| init_i | input | 1 | Synchronous initialise strobe, highest priority |
| stage_q_i | input | N_STAGES | Captured stage outputs; bit s-1 is stage s |
| det_o | output | N_STAGES-3 | Detect element of each cell |
| det_n_o | output | N_STAGES-3 | Inverse of the detect vector |
| xover_seen_o | output | 1 | Sticky crossover flag |
| xover_idx_o | output | clog2(N_STAGES-2) | Lowest cell with detect 0, all ones if none |

## Verification
A wrong arm element stays hidden at the ports until the next stage of that cell disagrees with the detect value. The error then shows in `det_o` and in the index two edges after the own stage is sampled. A wrong detect element or a broken enable path shows in `det_o` one edge after the bad load. If the error is in the ripple, it moves the index or the zero pattern one cell per clock from there on. A sticky flag that wrongly clears shows at once in the first cycle where every detect bit is back at 1. The bench therefore runs a cycle-accurate reference model and compares all outputs every cycle, so any such error is caught in the cycle where it first reaches a port.

// File: rtl/bdc_pkg.sv
package bdc_pkg;

   // Lowest stage number that owns a detect cell
   localparam int unsigned FIRST_STAGE = 3;

   // Variants of the lowest-zero encoder
   typedef enum logic [0:0] {
      ENC_SCAN    = 1'b0,
      ENC_ISOLATE = 1'b1
   } enc_style_e;

   // Number of detect cells for a line of n stages
   function automatic int unsigned cell_count(input int unsigned n);
      return n - FIRST_STAGE;
   endfunction

   // Index width able to hold every cell number plus an all-ones "none" code
   function automatic int unsigned idx_width(input int unsigned n);
      int unsigned w;
      w = $clog2(cell_count(n) + 1);
      return (w < 1) ? 1 : w;
   endfunction

endpackage

// File: rtl/bdc_cell.sv
module bdc_cell (
   input  logic clk_i,
   input  logic init_i,
   input  logic own_q_i,
   input  logic next_q_i,
   input  logic prev_det_n_i,
   output logic det_o
);

   logic arm_q;
   logic det_q;
   logic load_en;

   // Arm element: captures a constant one while its own stage is high
   always_ff @(posedge clk_i) begin
      if (init_i)
         arm_q <= 1'b0;
      else if (own_q_i)
         arm_q <= 1'b1;
   end

   // Detect element: follows the next stage while enabled
   assign load_en = arm_q | prev_det_n_i;

   always_ff @(posedge clk_i) begin
      if (init_i)
         det_q <= 1'b1;
      else if (load_en)
         det_q <= next_q_i;
   end

   assign det_o = det_q;

   // R1
   arm_sticky_chk: assert property (@(posedge clk_i) disable iff (init_i)
      arm_q |=> arm_q);

   // R1
   arm_set_chk: assert property (@(posedge clk_i) disable iff (init_i)
      own_q_i |=> arm_q);

   // R2
   init_state_chk: assert property (@(posedge clk_i) disable iff (init_i)
      $fell(init_i) |-> (!arm_q && det_q));

   // R3
   det_hold_chk: assert property (@(posedge clk_i) disable iff (init_i)
      (!arm_q && !prev_det_n_i) |=> $stable(det_q));

   // R4
   det_load_chk: assert property (@(posedge clk_i) disable iff (init_i)
      (arm_q || prev_det_n_i) |=> (det_q == $past(next_q_i)));

endmodule

// File: rtl/bdc_lowest_zero.sv
module bdc_lowest_zero
   import bdc_pkg::*;
#(
   parameter int unsigned WIDTH     = 13,
   parameter int unsigned IDX_W     = 4,
   parameter enc_style_e  ENC_STYLE = ENC_SCAN
) (
   input  logic [WIDTH-1:0] vec_i,
   output logic [IDX_W-1:0] idx_o
);

   localparam logic [IDX_W-1:0] IDX_NONE = '1;

   if (WIDTH < 1) begin : g_bad_width
      $error("bdc_lowest_zero: WIDTH must be at least 1");
   end
   if ((2 ** IDX_W) < (WIDTH + 1)) begin : g_bad_idx
      $error("bdc_lowest_zero: IDX_W too small to hold a none code");
   end

   logic [WIDTH-1:0] zeros;
   assign zeros = ~vec_i;

   if (ENC_STYLE == ENC_SCAN) begin : g_scan
      // Walk from the top down so the lowest zero wins last
      always_comb begin
         idx_o = IDX_NONE;
         for (int i = WIDTH - 1; i >= 0; i--) begin
            if (zeros[i])
               idx_o = IDX_W'(i);
         end
      end
   end else begin : g_isolate
      // Keep only the lowest set bit, then turn that one-hot into binary
      logic [WIDTH-1:0] lowest;
      logic [IDX_W-1:0] bin;
      assign lowest = zeros & (~zeros + WIDTH'(1));
      always_comb begin
         bin = '0;
         for (int i = 0; i < WIDTH; i++) begin
            if (lowest[i])
               bin = bin | IDX_W'(i);
         end
      end
      assign idx_o = (|zeros) ? bin : IDX_NONE;
   end

endmodule

// File: rtl/bdc_seen_tracker.sv
module bdc_seen_tracker #(
   parameter int unsigned WIDTH = 13
) (
   input  logic             clk_i,
   input  logic             init_i,
   input  logic [WIDTH-1:0] det_n_i,
   output logic             seen_o
);

   logic seen_q;
   logic any_now;

   assign any_now = |det_n_i;

   always_ff @(posedge clk_i) begin
      if (init_i)
         seen_q <= 1'b0;
      else if (any_now)
         seen_q <= 1'b1;
   end

   assign seen_o = seen_q | any_now;

   // R6
   seen_sticky_chk: assert property (@(posedge clk_i) disable iff (init_i)
      seen_o |=> seen_o);

   // R2
   seen_clear_chk: assert property (@(posedge clk_i) disable iff (init_i)
      $fell(init_i) |-> !seen_q);

endmodule

// File: rtl/boundary_detect_chain.sv
module boundary_detect_chain
   import bdc_pkg::*;
#(
   parameter int unsigned N_STAGES  = 16,
   parameter enc_style_e  ENC_STYLE = ENC_SCAN,
   localparam int unsigned NCELL    = cell_count(N_STAGES),
   localparam int unsigned IDX_W    = idx_width(N_STAGES)
) (
   input  logic              clk_i,
   input  logic              init_i,
   input  logic [N_STAGES-1:0] stage_q_i,
   output logic [NCELL-1:0]  det_o,
   output logic [NCELL-1:0]  det_n_o,
   output logic              xover_seen_o,
   output logic [IDX_W-1:0]  xover_idx_o
);

   localparam logic [IDX_W-1:0] IDX_NONE = '1;
   localparam int unsigned      PAD_W    = 2 ** IDX_W;

   if (N_STAGES < 4 || N_STAGES > 64) begin : g_bad_stages
      $error("boundary_detect_chain: N_STAGES must lie in 4..64");
   end

   logic [NCELL-1:0] det_w;
   logic [NCELL-1:0] det_n_w;

   // One cell per stage pair; cell c owns stage c+3, watches stage c+4
   for (genvar c = 0; c < NCELL; c++) begin : g_cell
      logic prev_n;
      if (c == 0) begin : g_head
         assign prev_n = 1'b0;
      end else begin : g_link
         assign prev_n = det_n_w[c-1];
      end

      bdc_cell u_cell (
         .clk_i        (clk_i),
         .init_i       (init_i),
         .own_q_i      (stage_q_i[FIRST_STAGE - 1 + c]),
         .next_q_i     (stage_q_i[FIRST_STAGE + c]),
         .prev_det_n_i (prev_n),
         .det_o        (det_w[c])
      );

      assign det_n_w[c] = ~det_w[c];
   end

   bdc_lowest_zero #(
      .WIDTH     (NCELL),
      .IDX_W     (IDX_W),
      .ENC_STYLE (ENC_STYLE)
   ) u_enc (
      .vec_i (det_w),
      .idx_o (xover_idx_o)
   );

   bdc_seen_tracker #(
      .WIDTH (NCELL)
   ) u_seen (
      .clk_i   (clk_i),
      .init_i  (init_i),
      .det_n_i (det_n_w),
      .seen_o  (xover_seen_o)
   );

   assign det_o   = det_w;
   assign det_n_o = det_n_w;

   // Padded copy so the reported index can address a detect bit safely
   logic [PAD_W-1:0] det_pad;
   assign det_pad = {{(PAD_W - NCELL){1'b1}}, det_w};

   // R7
   idx_none_chk: assert property (@(posedge clk_i) disable iff (init_i)
      (xover_idx_o == IDX_NONE) == (&det_o));

   // R7
   idx_points_zero_chk: assert property (@(posedge clk_i) disable iff (init_i)
      (xover_idx_o != IDX_NONE) |-> !det_pad[xover_idx_o]);

   // R6
   seen_covers_chk: assert property (@(posedge clk_i) disable iff (init_i)
      (xover_idx_o != IDX_NONE) |-> xover_seen_o);

endmodule

// File: tb/boundary_detect_chain_bench.sv
`timescale 1ns/1ps
module boundary_detect_chain_bench;

   localparam int N     = 16;
   localparam int NC    = N - 3;
   localparam int IW    = 4;
   localparam logic [IW-1:0] NONE = '1;

   logic          clk = 1'b0;
   logic          init;
   logic [N-1:0]  stage_q;
   logic [NC-1:0] det, det_n;
   logic          seen;
   logic [IW-1:0] idx;

   int tests = 0;
   int fails = 0;

   // reference model state
   logic [NC-1:0] m_arm, m_det;
   logic          m_seen_q;

   always #2 clk = ~clk;

   boundary_detect_chain #(.N_STAGES(N)) u_boundary_detect_chain (
      .clk_i        (clk),
      .init_i       (init),
      .stage_q_i    (stage_q),
      .det_o        (det),
      .det_n_o      (det_n),
      .xover_seen_o (seen),
      .xover_idx_o  (idx)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [IW-1:0] model_idx();
      logic [IW-1:0] r = NONE;
      for (int c = NC - 1; c >= 0; c--)
         if (!m_det[c]) r = IW'(c);
      return r;
   endfunction

   function automatic logic model_seen();
      return m_seen_q | (|(~m_det));
   endfunction

   // Reference update from the requirements (cell c: own stage c+3 -> bit c+2)
   task automatic model_edge(input logic [N-1:0] q, input logic ini);
      logic [NC-1:0] na, nd;
      if (ini) begin
         m_arm = '0; m_det = '1; m_seen_q = 1'b0;
      end else begin
         for (int c = 0; c < NC; c++) begin
            logic en;
            en    = m_arm[c] | ((c > 0) ? ~m_det[c-1] : 1'b0);
            na[c] = m_arm[c] | q[c+2];
            nd[c] = en ? q[c+3] : m_det[c];
         end
         m_seen_q = m_seen_q | (|(~m_det));
         m_arm = na; m_det = nd;
      end
   endtask

   // One clock: drive after a falling edge, compare at the next falling edge
   task automatic step(input logic [N-1:0] q, input logic ini);
      stage_q = q; init = ini;
      @(posedge clk);
      model_edge(q, ini);
      @(negedge clk);
      chk(det == m_det, "R3", "det vector", 64'(det), 64'(m_det));
      chk(det_n == ~m_det, "R5", "det_n vector", 64'(det_n), 64'(~m_det));
      chk(seen == model_seen(), "R6", "seen flag", 64'(seen), 64'(model_seen()));
      chk(idx == model_idx(), "R7", "index", 64'(idx), 64'(model_idx()));
   endtask

   task automatic t_reset();
      step('1, 1'b1);
      chk(det == '1, "R2", "det after init", 64'(det), 64'h1fff);
      chk(det_n == '0, "R2", "det_n after init", 64'(det_n), 64'h0);
      chk(seen == 1'b0, "R2", "seen after init", 64'(seen), 64'h0);
      chk(idx == NONE, "R2", "idx after init", 64'(idx), 64'(NONE));
   endtask

   task automatic t_thermo();
      step('0, 1'b1);
      step(16'h003F, 1'b0);            // stages 1..6 high, arms cells 0..3
      chk(det == '1, "R1", "no load before arm", 64'(det), 64'h1fff);
      step(16'h003F, 1'b0);            // cell 3 sees stage 7 low
      chk(idx == IW'(3), "R7", "thermo idx", 64'(idx), 64'h3);
      step(16'h003F, 1'b0);            // cell 4 unarmed, forced by ripple
      chk(det[4] == 1'b0, "R4", "ripple into unarmed cell", 64'(det[4]), 64'h0);
      for (int k = 0; k < 12; k++) step(16'h003F, 1'b0);
      chk(det == 13'h0007, "R4", "ripple reaches top", 64'(det), 64'h0007);
   endtask

   task automatic t_ignored();
      step('0, 1'b1);
      for (int k = 0; k < 5; k++) step(16'h8003, 1'b0);  // no own stage high
      chk(det == '1, "R3", "unarmed cells hold", 64'(det), 64'h1fff);
      chk(seen == 1'b0, "R3", "no crossover flagged", 64'(seen), 64'h0);
   endtask

   task automatic t_arm_sticky_recover();
      step('0, 1'b1);
      step(16'h0004, 1'b0);            // stage 3 high for one cycle
      step(16'h0000, 1'b0);            // dropped, cell 0 still armed
      chk(det[0] == 1'b0, "R1", "arm kept after stage drop", 64'(det[0]), 64'h0);
      chk(idx == IW'(0), "R7", "idx cell 0", 64'(idx), 64'h0);
      for (int k = 0; k < 20; k++) step('1, 1'b0);
      chk(det == '1, "R3", "detects recover", 64'(det), 64'h1fff);
      chk(idx == NONE, "R7", "idx none after recover", 64'(idx), 64'(NONE));
      chk(seen == 1'b1, "R6", "flag stays sticky", 64'(seen), 64'h1);
   endtask

   task automatic t_init_mid();
      step(16'h0007, 1'b0);
      step(16'h0007, 1'b0);
      step('1, 1'b1);                  // init wins over all-ones stages
      chk(seen == 1'b0, "R2", "init overrides flag", 64'(seen), 64'h0);
      chk(det == '1, "R2", "init overrides det", 64'(det), 64'h1fff);
      for (int k = 0; k < 4; k++) step('1, 1'b0);
   endtask

   task automatic t_two_zero();
      step('0, 1'b1);
      for (int k = 0; k < 4; k++) step(16'h00F7, 1'b0);
      chk(idx == IW'(0), "R7", "lowest of several zeros", 64'(idx), 64'h0);
   endtask

   task automatic t_walk();
      for (int s = 3; s <= N; s++) begin
         logic [N-1:0] q;
         logic [IW-1:0] e;
         q = (s == N) ? '1 : N'((32'd1 << s) - 1);
         e = (s == N) ? NONE : IW'(s - 3);
         step('0, 1'b1);
         step(q, 1'b0);
         step(q, 1'b0);
         chk(idx == e, "R7", $sformatf("walk boundary stage %0d", s), 64'(idx), 64'(e));
      end
   endtask

   initial begin
      init = 1'b1; stage_q = '0;
      m_arm = '0; m_det = '1; m_seen_q = 1'b0;
      @(negedge clk);
      t_reset();
      t_thermo();
      t_ignored();
      t_arm_sticky_recover();
      t_init_mid();
      t_two_zero();
      t_walk();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule